// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor's single-word load/store port and a line-wide memory port. Each set holds two lines. The selected set is looked up in both ways at once. A hit is answered without touching memory. A miss stalls the processor while the cache chooses a way to replace, writes that way's line back if it holds modified data, fetches the requested line and then finishes the access.

Stores use write-back with write-allocate. A store hit changes only the cached copy and marks the line modified. A store miss first brings the whole line in, merges the store word into it, and installs it as modified. Replacement fills an empty way before it displaces a valid one. When both ways are valid, it displaces the way that was used less recently. One recency bit per set tracks this and is updated by every hit and every fill.

The processor holds a request (`cpu_req` with address, direction and data) until it sees a one-cycle `cpu_done`. During that done cycle a request still on the pins is not taken. The memory side uses a request/acknowledge handshake, one whole line per transaction.

Top module: `wb_cache2w`

## Requirements
- R1: After reset every line is invalid and unmodified and every recency bit is cleared. `cpu_stall`, `cpu_done` and `mem_req` are low, and the first access to any address misses.
- R2: A byte address splits into tag (upper bits), set index (the next log2(SETS) bits) and line offset (the low log2(LINE_WORDS*DATA_W/8) bits). The word within a line is taken from the offset bits above the byte bits, so the set index equals the line number modulo SETS. Lines in different sets never displace each other.
- R3: A load that matches a valid tag in either way of its set returns the stored word with `cpu_done` and makes no memory transaction.
- R4: On a miss, if a way of the set is invalid, that way receives the new line and no valid line is displaced.
- R5: On a miss with both ways valid, the way not marked as most recently used is replaced. Every hit and every fill marks the touched way as most recently used.
- R6: A store hit updates only the cached word, makes no memory transaction and marks the line modified.
- R7: When the replaced line is modified, its full line is written to memory at the line address rebuilt from its own tag and set. This happens before the refill read is issued, and later reads of that line return the stored data.
- R8: A store miss reads the line from memory, replaces only the addressed word with the store data, and installs the line as modified. The other words keep their memory values.
- R9: `cpu_stall` is high from the cycle after a request is taken until `cpu_done` pulses for one cycle. A request present during the done cycle is not taken.
- R10: `mem_req` is raised only while an access is stalled. It stays high with its address and direction stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| cpu_stall | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_W | Line being written back |
| mem_rdata | input | LINE_W | Line returned by memory |
| mem_ack | input | 1 | One-cycle acknowledge completing the transaction |

## Verification
The hardest case to reach is the eviction of a modified line. It needs a set whose two ways are both valid, with the less recently used way dirty, at the moment a third tag misses into that set. The bench uses only two sets and sixteen lines, so that conflicts happen constantly. It first walks a directed order (lines 0, 8, 0, 6, 8, then a store hit, then a conflicting load) and then runs a long pseudo-random mix of loads and stores. A bench-side model of tags, recency and modified bits predicts every refill, every write-back and its address, and every returned word.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int NWAY  = 2;
  localparam int WAY_W = 1;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_WB   = 2'd2,
    S_FILL = 2'd3
  } cstate_t;
endpackage

// File: rtl/wbc_sram.sv
module wbc_sram #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wbc_meta.sv
module wbc_meta
  import wbc_pkg::*;
#(
  parameter int SETS = 32,
  localparam int IW  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    idx,
  output logic [NWAY-1:0]  vld,
  output logic [NWAY-1:0]  drt,
  output logic             mru,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             fill_dirty,
  input  logic             mark_en,
  input  logic [WAY_W-1:0] mark_way,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  logic [NWAY-1:0] vld_q [SETS];
  logic [NWAY-1:0] drt_q [SETS];
  logic [SETS-1:0] mru_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SETS; i++) begin
        vld_q[i] <= '0;
        drt_q[i] <= '0;
      end
      mru_q <= '0;
    end else begin
      if (fill_en) begin
        vld_q[idx][fill_way] <= 1'b1;
        drt_q[idx][fill_way] <= fill_dirty;
      end
      if (mark_en) drt_q[idx][mark_way] <= 1'b1;
      if (touch_en) mru_q[idx] <= touch_way;
    end
  end

  assign vld = vld_q[idx];
  assign drt = drt_q[idx];
  assign mru = mru_q[idx];
endmodule

// File: rtl/wbc_victim.sv
module wbc_victim
  import wbc_pkg::*;
(
  input  logic [NWAY-1:0]  vld,
  input  logic             mru,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    if (!vld[0])      way = 1'b0;
    else if (!vld[1]) way = 1'b1;
    else              way = ~mru;
  end
endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W    = DATA_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WSEL_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  cstate_t           state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  victim_q;

  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [IDX_W-1:0]  rd_idx;
  logic              unused_bits;

  assign tag_q       = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_q       = addr_q[OFF_W +: IDX_W];
  assign wsel_q      = addr_q[BYTE_W +: WSEL_W];
  assign rd_idx      = cpu_addr[OFF_W +: IDX_W];
  assign unused_bits = ^{addr_q[BYTE_W-1:0], cpu_addr[OFF_W-1:0], cpu_addr[ADDR_W-1 -: TAG_W]};

  logic accept;
  assign accept = (state_q == S_IDLE) && cpu_req && !cpu_done;

  // per-way storage
  logic [TAG_W-1:0]  tag_rd  [NWAY];
  logic [LINE_W-1:0] line_rd [NWAY];
  logic [NWAY-1:0]   way_we;
  logic [LINE_W-1:0] wr_line;

  for (genvar g = 0; g < NWAY; g++) begin : g_way
    wbc_sram #(.W(TAG_W), .DEPTH(SETS)) u_tag (
      .clk(clk), .re(accept), .raddr(rd_idx), .rdata(tag_rd[g]),
      .we(way_we[g]), .waddr(idx_q), .wdata(tag_q)
    );
    wbc_sram #(.W(LINE_W), .DEPTH(SETS)) u_line (
      .clk(clk), .re(accept), .raddr(rd_idx), .rdata(line_rd[g]),
      .we(way_we[g]), .waddr(idx_q), .wdata(wr_line)
    );
  end

  // metadata
  logic [NWAY-1:0]  vld, drt;
  logic             mru;
  logic             fill_en, mark_en, touch_en;
  logic [WAY_W-1:0] touch_way;

  logic [NWAY-1:0]  hit_vec;
  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;

  for (genvar g = 0; g < NWAY; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tag_rd[g] == tag_q);
  end
  assign hit_any = |hit_vec;
  assign hit_way = hit_vec[1];

  wbc_meta #(.SETS(SETS)) u_meta (
    .clk(clk), .rst(rst), .idx(idx_q),
    .vld(vld), .drt(drt), .mru(mru),
    .fill_en(fill_en), .fill_way(victim_q), .fill_dirty(we_q),
    .mark_en(mark_en), .mark_way(hit_way),
    .touch_en(touch_en), .touch_way(touch_way)
  );

  wbc_victim u_victim (.vld(vld), .mru(mru), .way(victim));

  logic look_hit, fill_fin;
  assign look_hit  = (state_q == S_LOOK) && hit_any;
  assign fill_fin  = (state_q == S_FILL) && mem_ack;
  assign fill_en   = fill_fin;
  assign mark_en   = look_hit && we_q;
  assign touch_en  = look_hit || fill_fin;
  assign touch_way = look_hit ? hit_way : victim_q;

  // line merge and write enables
  always_comb begin
    wr_line = (state_q == S_FILL) ? mem_rdata : line_rd[hit_way];
    if (we_q) wr_line[wsel_q*DATA_W +: DATA_W] = wdata_q;
    for (int g = 0; g < NWAY; g++) begin
      way_we[g] = (look_hit && we_q && (hit_way == WAY_W'(g))) ||
                  (fill_fin && (victim_q == WAY_W'(g)));
    end
  end

  // control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      addr_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      victim_q  <= '0;
      cpu_stall <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            addr_q    <= cpu_addr;
            we_q      <= cpu_we;
            wdata_q   <= cpu_wdata;
            cpu_stall <= 1'b1;
            state_q   <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit_any) begin
            if (!we_q) cpu_rdata <= line_rd[hit_way][wsel_q*DATA_W +: DATA_W];
            cpu_stall <= 1'b0;
            cpu_done  <= 1'b1;
            state_q   <= S_IDLE;
          end else begin
            victim_q <= victim;
            mem_req  <= 1'b1;
            if (vld[victim] && drt[victim]) begin
              mem_we    <= 1'b1;
              mem_addr  <= {tag_rd[victim], idx_q, {OFF_W{1'b0}}};
              mem_wdata <= line_rd[victim];
              state_q   <= S_WB;
            end else begin
              mem_we   <= 1'b0;
              mem_addr <= {tag_q, idx_q, {OFF_W{1'b0}}};
              state_q  <= S_FILL;
            end
          end
        end
        S_WB: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= {tag_q, idx_q, {OFF_W{1'b0}}};
            state_q  <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            if (!we_q) cpu_rdata <= mem_rdata[wsel_q*DATA_W +: DATA_W];
            cpu_stall <= 1'b0;
            cpu_done  <= 1'b1;
            state_q   <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_stall,
  input logic              cpu_done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  // R1: quiet outputs right after reset
  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!cpu_stall && !cpu_done && !mem_req));

  // R9: done is a single-cycle pulse and never overlaps stall
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_stall);
  p_stall_until_done_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_stall && !cpu_done) |=> (cpu_stall || cpu_done));

  // R10: memory traffic only during a stall, held stable until acknowledged
  p_req_in_stall_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cpu_stall);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7: an acknowledged write-back is followed straight away by the refill read
  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R8: an acknowledged refill completes the access
  p_fill_done_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack) |=> cpu_done);
endmodule

bind wb_cache2w wbc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/sim_wb_cache2w.sv
module sim_wb_cache2w;
  localparam int CLK_PERIOD = 10;
  localparam int SETS       = 2;
  localparam int NBLK       = 16;
  localparam int LAT        = 3;

  logic         clk = 1'b0;
  logic         rst;
  logic         cpu_req, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
  logic         cpu_stall, cpu_done;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata;

  wb_cache2w #(.SETS(SETS)) u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // backing memory and golden word image
  logic [127:0] bmem [NBLK];
  logic [31:0]  shadow [NBLK*4];
  int           n_fill = 0, n_wb = 0;
  logic [31:0]  last_wb_addr = '0;

  function automatic logic [31:0] pat(int b, int w);
    return 32'hA000_0000 | (b << 8) | w;
  endfunction

  initial begin
    for (int b = 0; b < NBLK; b++)
      for (int w = 0; w < 4; w++) begin
        bmem[b][w*32 +: 32] = pat(b, w);
        shadow[b*4+w]       = pat(b, w);
      end
  end

  // memory responder
  initial begin
    int cnt;
    cnt = 0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        cnt++;
        if (cnt == LAT) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            bmem[mem_addr[7:4]] = mem_wdata;
            last_wb_addr = mem_addr;
            n_wb++;
          end else begin
            mem_rdata = bmem[mem_addr[7:4]];
            n_fill++;
          end
        end
      end
    end
  end

  // reference model of tags, valid, dirty and recency
  int r_tag   [SETS][2];
  bit r_val   [SETS][2];
  bit r_dirty [SETS][2];
  int r_mru   [SETS];

  task automatic access(int blk, int w, bit we, logic [31:0] d, output bit was_hit);
    int  s, t, hw, v, f0, b0, guard;
    bit  exp_wb, prev_stall;
    logic [31:0] exp_wb_addr;
    s = blk % SETS;
    t = blk / SETS;
    hw = -1;
    for (int k = 0; k < 2; k++) if (r_val[s][k] && r_tag[s][k] == t) hw = k;
    if (!r_val[s][0]) v = 0;
    else if (!r_val[s][1]) v = 1;
    else v = 1 - r_mru[s];
    exp_wb = (hw < 0) && r_val[s][v] && r_dirty[s][v];
    exp_wb_addr = 32'((r_tag[s][v] * SETS + s) * 16);
    f0 = n_fill;
    b0 = n_wb;
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = 32'(blk*16 + w*4);
    cpu_wdata = d;
    prev_stall = 1'b0;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (cpu_done || guard > 100) break;
      prev_stall = cpu_stall;
    end
    cpu_req = 1'b0;
    chk(cpu_done == 1'b1, "R9 done", 64'(cpu_done), 64'd1);
    chk(prev_stall == 1'b1, "R9 stall", 64'(prev_stall), 64'd1);
    chk((n_fill - f0) == ((hw < 0) ? 1 : 0), (hw < 0) ? "R5 refill" : "R3 hit",
        64'(n_fill - f0), 64'((hw < 0) ? 1 : 0));
    chk((n_wb - b0) == int'(exp_wb), "R7 writeback count", 64'(n_wb - b0), 64'(exp_wb));
    if (exp_wb)
      chk(last_wb_addr == exp_wb_addr, "R7 writeback addr", 64'(last_wb_addr), 64'(exp_wb_addr));
    if (!we)
      chk(cpu_rdata == shadow[blk*4+w], "R3 R8 load data", 64'(cpu_rdata), 64'(shadow[blk*4+w]));
    if (hw >= 0) begin
      if (we) r_dirty[s][hw] = 1'b1;
      r_mru[s] = hw;
    end else begin
      r_tag[s][v] = t;
      r_val[s][v] = 1'b1;
      r_dirty[s][v] = we;
      r_mru[s] = v;
    end
    if (we) shadow[blk*4+w] = d;
    was_hit = (hw >= 0) && (n_fill == f0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit h;
    logic [15:0] lfsr;
    for (int s = 0; s < SETS; s++) begin
      r_mru[s] = 0;
      for (int k = 0; k < 2; k++) begin
        r_val[s][k] = 0; r_dirty[s][k] = 0; r_tag[s][k] = 0;
      end
    end
    rst = 1'b1;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!cpu_stall, "R1 stall", 64'(cpu_stall), 64'd0);
    chk(!cpu_done, "R1 done", 64'(cpu_done), 64'd0);
    chk(!mem_req, "R1 mem_req", 64'(mem_req), 64'd0);

    // lines 0, 8, 0, 6, 8 all fall in set 0 with two sets
    access(0, 0, 0, '0, h);  chk(!h, "R1 first access misses", 64'(h), 64'd0);
    access(8, 1, 0, '0, h);  chk(!h, "R4 line 8 misses", 64'(h), 64'd0);
    access(0, 2, 0, '0, h);  chk(h,  "R4 line 0 kept in other way", 64'(h), 64'd1);
    access(6, 3, 0, '0, h);  chk(!h, "R5 line 6 misses", 64'(h), 64'd0);
    access(8, 0, 0, '0, h);  chk(!h, "R5 line 8 was displaced", 64'(h), 64'd0);
    access(6, 0, 0, '0, h);  chk(h,  "R5 line 6 still held", 64'(h), 64'd1);

    // R6 store hit, then R7 displacement of the modified line
    access(8, 1, 1, 32'hDEAD_BEEF, h); chk(h, "R6 store hit", 64'(h), 64'd1);
    access(6, 2, 0, '0, h);  chk(h, "R6 no traffic before", 64'(h), 64'd1);
    access(0, 0, 0, '0, h);  chk(!h, "R7 conflict miss", 64'(h), 64'd0);
    chk(last_wb_addr == 32'd128, "R7 written line is 8", 64'(last_wb_addr), 64'd128);
    access(8, 1, 0, '0, h);  chk(cpu_rdata == 32'hDEAD_BEEF, "R7 data survives", 64'(cpu_rdata), 64'hDEAD_BEEF);

    // R8 store miss merges into the fetched line; R2 other set undisturbed
    access(3, 2, 1, 32'hCAFE_0123, h); chk(!h, "R8 store miss", 64'(h), 64'd0);
    access(3, 2, 0, '0, h);  chk(h && cpu_rdata == 32'hCAFE_0123, "R8 merged word", 64'(cpu_rdata), 64'hCAFE_0123);
    access(3, 0, 0, '0, h);  chk(h && cpu_rdata == pat(3, 0), "R8 other word kept", 64'(cpu_rdata), 64'(pat(3, 0)));
    access(8, 1, 0, '0, h);  chk(h, "R2 set 0 untouched by set 1", 64'(h), 64'd1);

    // R9 request left high in the done cycle is not taken
    access(3, 1, 0, '0, h);
    cpu_req = 1'b1;
    @(negedge clk);
    chk(!cpu_stall && !cpu_done, "R9 done-cycle request ignored", 64'(cpu_stall), 64'd0);
    cpu_req = 1'b0;
    repeat (2) @(negedge clk);

    // R2 sweep of mixed loads and stores over 16 lines and 2 sets
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(int'(lfsr[3:0]), int'(lfsr[5:4]), lfsr[7] & lfsr[11], {lfsr, ~lfsr}, h);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule